// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block is a numerically controlled oscillator for a composite video encoder. On every encoder clock it adds a 32-bit frequency word to a 32-bit phase accumulator. The frequency word is chosen per video standard as round(Fsc / Fclk × 2^32). The ten most significant phase bits address a quarter-wave-folded sine table. The table returns signed sine and cosine samples of the colour subcarrier, which a modulator outside the block uses.

The phase can be forced back to a programmed start phase in step with video timing. A two-bit mode input selects the rule. The phase can run freely, restart on every field, restart once per colour sequence of fields (eight fields for PAL, four for NTSC), or restart on every line. The line and field strobes come from the encoder's timing generator. The restart brings the subcarrier back to a known phase relative to sync.

Top module: `subcarrierNco`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `phase` reads 0 and the field counter is cleared to 0.
- R2: With `resetMode` = 00 (free run), each rising clock edge sets `phase` to the previous `phase` plus the `increment` present at that edge, modulo 2^32. `lineStart` and `fieldStart` have no effect on `phase`.
- R3: With `resetMode` = 01 (field restart), a clock edge with `fieldStart` high loads `phase` with `phaseOffset`. `lineStart` has no effect.
- R4: A field counter advances on every `fieldStart` pulse in every mode. It wraps after 8 pulses when `palMode` = 1 and after 4 pulses when `palMode` = 0. With `resetMode` = 10 (sequence restart), a `fieldStart` edge loads `phaseOffset` only while the counter reads 0, so the first pulse after reset restarts the phase and every 8th (PAL) or 4th (NTSC) pulse after it does too.
- R5: With `resetMode` = 11 (line restart), a clock edge with `lineStart` high loads `phase` with `phaseOffset`. `fieldStart` has no effect on `phase`.
- R6: A restart takes priority over the increment in the same edge. Right after a restart, `phase` equals `phaseOffset` exactly, and the increment is added again from the next edge.
- R7: `sinOut` is a signed two's-complement 9-bit value equal to round(255 × sin(2π(k + 0.5)/1024)), where k = `phase`[31:22]. It follows `phase` in the same cycle.
- R8: `cosOut` is a signed two's-complement 9-bit value equal to round(255 × cos(2π(k + 0.5)/1024)), with the same k as R7.
- R9: With the 27 MHz standard words 0x21F07C1F (NTSC), 0x2A098ACB (PAL-B/D/G/H/I) and 0x21E6EFE3 (PAL-M), `phase` after N free-running edges equals (start + N × word) mod 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Encoder clock |
| rstN | input | 1 | Synchronous active-low reset |
| increment | input | 32 | Phase step added every clock |
| phaseOffset | input | 32 | Start phase loaded on a timing restart |
| resetMode | input | 2 | Restart rule: 00 none, 01 field, 10 colour sequence, 11 line |
| palMode | input | 1 | 1 selects an 8-field sequence, 0 a 4-field sequence |
| lineStart | input | 1 | One-cycle pulse at the start of each line |
| fieldStart | input | 1 | One-cycle pulse at the start of each field |
| phase | output | 32 | Accumulated subcarrier phase |
| sinOut | output | 9 | Signed sine sample of the phase |
| cosOut | output | 9 | Signed cosine sample of the phase |

## Verification
The assertions assume that the mode, frequency word and start phase are known values on every clock after reset. They also assume that the timing strobes are single-cycle pulses from a timing source. The stimulus changes every input only at the falling clock edge and holds it stable across the rising edge. It raises each strobe for exactly one cycle, and it changes `palMode` only while reset is held, so the field sequence count is always defined. The amplitude check allows for table rounding only. Every sample therefore has to come from the quarter-wave fold applied to a valid ten-bit address.

// File: rtl/subcarrierNco_pkg.sv
package subcarrierNco_pkg;

  typedef enum logic [1:0] {
    RST_NONE  = 2'b00,
    RST_FIELD = 2'b01,
    RST_SEQ   = 2'b10,
    RST_LINE  = 2'b11
  } restartMode_e;

  typedef struct packed {
    logic loadPhase;
    logic advance;
  } ncoStrobe_t;

  localparam real TWO_PI = 6.283185307179586;

endpackage

// File: rtl/subcarrierNcoCtrl.sv
module subcarrierNcoCtrl
  import subcarrierNco_pkg::*;
#(
  parameter int PAL_FIELDS  = 8,
  parameter int NTSC_FIELDS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] resetMode,
  input  logic       palMode,
  input  logic       lineStart,
  input  logic       fieldStart,
  output ncoStrobe_t strobe
);

  localparam int CNT_W = (PAL_FIELDS > 2) ? $clog2(PAL_FIELDS) : 1;
  localparam logic [CNT_W-1:0] PAL_LAST  = CNT_W'(PAL_FIELDS - 1);
  localparam logic [CNT_W-1:0] NTSC_LAST = CNT_W'(NTSC_FIELDS - 1);

  logic [CNT_W-1:0] fieldCnt;
  logic [CNT_W-1:0] seqLast;
  logic             seqHit;
  restartMode_e     mode;

  assign mode    = restartMode_e'(resetMode);
  assign seqLast = palMode ? PAL_LAST : NTSC_LAST;
  assign seqHit  = fieldStart && (fieldCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fieldCnt <= '0;
    end else if (fieldStart) begin
      fieldCnt <= (fieldCnt >= seqLast) ? '0 : fieldCnt + 1'b1;
    end
  end

  always_comb begin
    strobe = '0;
    unique case (mode)
      RST_NONE:  strobe.loadPhase = 1'b0;
      RST_FIELD: strobe.loadPhase = fieldStart;
      RST_SEQ:   strobe.loadPhase = seqHit;
      RST_LINE:  strobe.loadPhase = lineStart;
      default:   strobe.loadPhase = 1'b0;
    endcase
    strobe.advance = !strobe.loadPhase;
  end

endmodule

// File: rtl/subcarrierNcoLut.sv
module subcarrierNcoLut
  import subcarrierNco_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 9
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam int QUARTER = 2 ** (ADDR_W - 2);
  localparam int FULL    = 2 ** ADDR_W;
  localparam int MAG_W   = SAMPLE_W - 1;
  localparam int AMPL    = 2 ** MAG_W - 1;

  function automatic logic [MAG_W-1:0] quarterValue(input int idx);
    real angle;
    angle = TWO_PI * (real'(idx) + 0.5) / real'(FULL);
    return MAG_W'($rtoi(real'(AMPL) * $sin(angle) + 0.5));
  endfunction

  logic [MAG_W-1:0] quarterRom [QUARTER];

  for (genvar g = 0; g < QUARTER; g++) begin : gRom
    assign quarterRom[g] = quarterValue(g);
  end

  logic [1:0]        quadrant;
  logic [ADDR_W-3:0] inQuad;
  logic [ADDR_W-3:0] romIdx;
  logic [MAG_W-1:0]  mag;

  assign quadrant = addr[ADDR_W-1 -: 2];
  assign inQuad   = addr[ADDR_W-3:0];
  assign romIdx   = quadrant[0] ? ~inQuad : inQuad;
  assign mag      = quarterRom[romIdx];
  assign sample   = quadrant[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});

endmodule

// File: rtl/subcarrierNcoPath.sv
module subcarrierNcoPath
  import subcarrierNco_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int ADDR_W   = 10,
  parameter int SAMPLE_W = 9
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ncoStrobe_t                 strobe,
  input  logic [PHASE_W-1:0]         increment,
  input  logic [PHASE_W-1:0]         phaseOffset,
  output logic [PHASE_W-1:0]         phase,
  output logic signed [SAMPLE_W-1:0] sinOut,
  output logic signed [SAMPLE_W-1:0] cosOut
);

  localparam int QUARTER_STEP = 2 ** (ADDR_W - 2);

  logic [PHASE_W-1:0] acc;
  logic [ADDR_W-1:0]  sinAddr;
  logic [ADDR_W-1:0]  cosAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (strobe.loadPhase) begin
      acc <= phaseOffset;
    end else if (strobe.advance) begin
      acc <= acc + increment;
    end
  end

  assign phase   = acc;
  assign sinAddr = acc[PHASE_W-1 -: ADDR_W];
  assign cosAddr = sinAddr + ADDR_W'(QUARTER_STEP);

  subcarrierNcoLut #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) sinLut_i (
    .addr  (sinAddr),
    .sample(sinOut)
  );

  subcarrierNcoLut #(.ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) cosLut_i (
    .addr  (cosAddr),
    .sample(cosOut)
  );

endmodule

// File: rtl/subcarrierNco.sv
module subcarrierNco
  import subcarrierNco_pkg::*;
#(
  parameter int PHASE_W     = 32,
  parameter int ADDR_W      = 10,
  parameter int SAMPLE_W    = 9,
  parameter int PAL_FIELDS  = 8,
  parameter int NTSC_FIELDS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [PHASE_W-1:0]         increment,
  input  logic [PHASE_W-1:0]         phaseOffset,
  input  logic [1:0]                 resetMode,
  input  logic                       palMode,
  input  logic                       lineStart,
  input  logic                       fieldStart,
  output logic [PHASE_W-1:0]         phase,
  output logic signed [SAMPLE_W-1:0] sinOut,
  output logic signed [SAMPLE_W-1:0] cosOut
);

  ncoStrobe_t strobe;

  subcarrierNcoCtrl #(.PAL_FIELDS(PAL_FIELDS), .NTSC_FIELDS(NTSC_FIELDS)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .resetMode (resetMode),
    .palMode   (palMode),
    .lineStart (lineStart),
    .fieldStart(fieldStart),
    .strobe    (strobe)
  );

  subcarrierNcoPath #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .SAMPLE_W(SAMPLE_W)) path_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .increment  (increment),
    .phaseOffset(phaseOffset),
    .phase      (phase),
    .sinOut     (sinOut),
    .cosOut     (cosOut)
  );

endmodule

// File: rtl/subcarrierNcoChecker.sv
module subcarrierNcoChecker #(
  parameter int PHASE_W  = 32,
  parameter int SAMPLE_W = 9
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [PHASE_W-1:0]         increment,
  input logic [PHASE_W-1:0]         phaseOffset,
  input logic [1:0]                 resetMode,
  input logic                       lineStart,
  input logic                       fieldStart,
  input logic [PHASE_W-1:0]         phase,
  input logic signed [SAMPLE_W-1:0] sinOut,
  input logic signed [SAMPLE_W-1:0] cosOut
);

  localparam int AMPL = 2 ** (SAMPLE_W - 1) - 1;
  localparam int AMPL_SQ = AMPL * AMPL;
  localparam int RADIUS_TOL = 2 * AMPL + 4;

  int sinSq;
  int cosSq;
  assign sinSq = int'(sinOut) * int'(sinOut);
  assign cosSq = int'(cosOut) * int'(cosOut);

  // R2: free running ignores strobes and adds the step
  a_r2_free_run: assert property (@(posedge clk) disable iff (!rstN)
    (resetMode == 2'b00) |=> (phase == $past(phase) + $past(increment)));

  // R3: field restart loads the start phase
  a_r3_field_restart: assert property (@(posedge clk) disable iff (!rstN)
    (resetMode == 2'b01 && fieldStart) |=> (phase == $past(phaseOffset)));

  // R5: line restart loads the start phase
  a_r5_line_restart: assert property (@(posedge clk) disable iff (!rstN)
    (resetMode == 2'b11 && lineStart) |=> (phase == $past(phaseOffset)));

  // R6: without a strobe in line mode the step is still applied
  a_r6_no_strobe_step: assert property (@(posedge clk) disable iff (!rstN)
    (resetMode == 2'b11 && !lineStart) |=> (phase == $past(phase) + $past(increment)));

  // R7, R8: the sample pair lies on the circle of the table amplitude
  a_r7_quadrature: assert property (@(posedge clk) disable iff (!rstN)
    ((sinSq + cosSq <= AMPL_SQ + RADIUS_TOL) && (sinSq + cosSq >= AMPL_SQ - RADIUS_TOL)));

  // R8: cosine never leaves the signed amplitude range
  a_r8_cos_range: assert property (@(posedge clk) disable iff (!rstN)
    (int'(cosOut) <= AMPL) && (int'(cosOut) >= -AMPL));

endmodule

bind subcarrierNco subcarrierNcoChecker #(.PHASE_W(PHASE_W), .SAMPLE_W(SAMPLE_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .increment  (increment),
  .phaseOffset(phaseOffset),
  .resetMode  (resetMode),
  .lineStart  (lineStart),
  .fieldStart (fieldStart),
  .phase      (phase),
  .sinOut     (sinOut),
  .cosOut     (cosOut)
);

// File: tb/subcarrierNco_tb.sv
module subcarrierNco_tb_top;

  localparam logic [31:0] NTSC_WORD = 32'h21F07C1F;
  localparam logic [31:0] PALB_WORD = 32'h2A098ACB;
  localparam logic [31:0] PALM_WORD = 32'h21E6EFE3;
  localparam real         PI2       = 6.283185307179586;

  logic               clk = 1'b0;
  logic               rstN;
  logic [31:0]        increment;
  logic [31:0]        phaseOffset;
  logic [1:0]         resetMode;
  logic               palMode;
  logic               lineStart;
  logic               fieldStart;
  logic [31:0]        phase;
  logic signed [8:0]  sinOut;
  logic signed [8:0]  cosOut;

  int checks = 0;
  int fails = 0;
  logic [31:0] expPhase;
  int fieldCount;
  bit done = 0;

  always #10 clk = ~clk;

  subcarrierNco dut_i (
    .clk(clk), .rstN(rstN), .increment(increment), .phaseOffset(phaseOffset),
    .resetMode(resetMode), .palMode(palMode), .lineStart(lineStart),
    .fieldStart(fieldStart), .phase(phase), .sinOut(sinOut), .cosOut(cosOut)
  );

  function automatic int expSample(input logic [31:0] p, input bit wantCos);
    real ang;
    real v;
    ang = PI2 * (real'(p[31:22]) + 0.5) / 1024.0;
    v = wantCos ? $cos(ang) : $sin(ang);
    return $rtoi($floor(255.0 * v + 0.5));
  endfunction

  task automatic checkPhase(input string req);
    checks++;
    if (phase !== expPhase) begin
      fails++;
      $display("FAIL %s phase actual %08h expected %08h", req, phase, expPhase);
    end
  endtask

  task automatic checkSamples(input string req);
    int es;
    int ec;
    es = expSample(phase, 1'b0);
    ec = expSample(phase, 1'b1);
    checks++;
    if (int'(sinOut) != es) begin
      fails++;
      $display("FAIL %s sin actual %0d expected %0d", req, sinOut, es);
    end
    checks++;
    if (int'(cosOut) != ec) begin
      fails++;
      $display("FAIL %s cos actual %0d expected %0d", req, cosOut, ec);
    end
  endtask

  task automatic doReset(input logic pal);
    rstN = 1'b0;
    palMode = pal;
    lineStart = 1'b0;
    fieldStart = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    expPhase = '0;
    fieldCount = 0;
  endtask

  // one clock: drive strobes, advance the reference, wait for the falling edge
  task automatic tick(input logic ls, input logic fs);
    bit load;
    int seqLen;
    lineStart = ls;
    fieldStart = fs;
    seqLen = palMode ? 8 : 4;
    case (resetMode)
      2'b01:   load = fs;
      2'b10:   load = fs && (fieldCount == 0);
      2'b11:   load = ls;
      default: load = 1'b0;
    endcase
    @(negedge clk);
    expPhase = load ? phaseOffset : expPhase + increment;
    if (fs) fieldCount = (fieldCount + 1) % seqLen;
    lineStart = 1'b0;
    fieldStart = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    increment = NTSC_WORD;
    phaseOffset = 32'h1234_5678;
    resetMode = 2'b00;
    rstN = 1'b0;
    palMode = 1'b0;
    lineStart = 1'b0;
    fieldStart = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R1: reset state
    expPhase = '0;
    checkPhase("R1");
    checkSamples("R1");
    doReset(1'b0);
    checkPhase("R1");

    // R2, R9: free run with the three standard words, strobes ignored
    for (int w = 0; w < 3; w++) begin
      increment = (w == 0) ? NTSC_WORD : (w == 1) ? PALB_WORD : PALM_WORD;
      for (int n = 0; n < 40; n++) begin
        tick(n % 7 == 3, n % 11 == 5);
        checkPhase(w == 0 ? "R2" : "R9");
      end
    end

    // R5, R6: line restart, field strobes ignored
    doReset(1'b1);
    resetMode = 2'b11;
    increment = PALB_WORD;
    phaseOffset = 32'h8000_0400;
    for (int n = 0; n < 60; n++) begin
      tick(n % 9 == 2, n % 5 == 1);
      checkPhase(n % 9 == 2 ? "R6" : "R5");
    end

    // R3: field restart, line strobes ignored
    resetMode = 2'b01;
    phaseOffset = 32'h4000_0001;
    for (int n = 0; n < 60; n++) begin
      tick(n % 3 == 0, n % 13 == 6);
      checkPhase("R3");
    end

    // R4: colour sequence restart, PAL then NTSC
    for (int p = 1; p >= 0; p--) begin
      doReset(p[0]);
      resetMode = 2'b10;
      increment = p[0] ? PALB_WORD : NTSC_WORD;
      phaseOffset = 32'h0F0F_0F0F;
      for (int f = 0; f < 18; f++) begin
        tick(1'b1, 1'b1);
        checkPhase("R4");
        tick(1'b0, 1'b0);
        checkPhase("R4");
        tick(1'b1, 1'b0);
        checkPhase("R4");
      end
    end

    // R7, R8: full table sweep, one address step per clock
    resetMode = 2'b11;
    increment = 32'h0040_0000;
    phaseOffset = 32'h0000_0000;
    tick(1'b1, 1'b0);
    checkPhase("R6");
    for (int n = 0; n < 1024; n++) begin
      checkSamples(n[0] ? "R8" : "R7");
      tick(1'b0, 1'b0);
    end
    // R7, R8: sub-step offsets do not change the address
    phaseOffset = 32'h003F_FFFF;
    tick(1'b1, 1'b0);
    checkPhase("R5");
    checkSamples("R7");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule